// File: doc/BRIEF.md
# DDR2 Read Burst Command Legality Monitor

The monitor sits beside the command bus of a DDR2 memory device. Each clock it receives a decoded command, a bank number, an auto-precharge flag and the burst length, additive latency and CAS latency in force. It keeps the timing context of the most recent READ and a per-bank record of open rows. From these it flags command sequences that break the read-burst rules: cutting a burst short, misaligning a truncation, writing over read data still in flight, or reading from a closed bank.

Each rule has its own error flag, and each flag stays set until reset. A one-cycle violation pulse marks every offending command, including one that breaks a rule already flagged. The open-row vector shows which banks the monitor considers active. The block has no side effects on the bus and is synthesizable, so it can run in emulation or silicon as well as in simulation.

Command codes on `cmd_i`: 0 no operation, 1 READ, 2 WRITE, 3 ACTIVATE, 4 PRECHARGE, 5 to 7 any other command. Time since a READ is counted as k, where k = 1 in the clock after the READ. Half-burst H is 2 for 4-beat bursts and 4 for 8-beat bursts. Read latency RL = `al_i` + `cl_i`.

Top module: `ddr2_rd_mon`

## Requirements
- R1: After reset all six error flags, `viol_o` and every bit of `row_open_o` read 0, and no READ context is active.
- R2: When the last READ was a 4-beat burst, any command other than code 0 at k < 2 sets `err_bl4_cut_o`.
- R3: When the last READ was an 8-beat burst, a command that is neither code 0 nor code 1 at k < 4 sets `err_bl8_cut_o`.
- R4: When the last READ was an 8-beat burst, a READ at k = 1 or k = 3 sets `err_bl8_align_o`. A READ at k = 2 does not.
- R5: When the last READ was an 8-beat burst with auto precharge, any READ at k < 4 sets `err_ap_cut_o`.
- R6: A WRITE at k < RL + H after the most recent READ sets `err_rd2wr_o`. At k = RL + H or later it does not.
- R7: A READ at exactly k = H raises no flag and no pulse, provided its target bank is open and the prior READ is not still closing that bank.
- R8: ACTIVATE sets `row_open_o[bank_i]`. PRECHARGE with `ap_i` = 0 clears that bank's bit. PRECHARGE with `ap_i` = 1 clears all bits. Each change is visible one clock after the command.
- R9: A READ with auto precharge clears its bank's bit at the clock edge where k = H, or at the next READ if that comes first. It does not clear the bit when it is issued. A READ to a bank whose bit is 0, or whose auto-precharge close is still pending, sets `err_closed_o`.
- R10: Every flag is sticky until reset. `viol_o` is high for exactly the one clock after each violating command. A code-0 command never causes a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Decoded command code |
| bank_i | input | BANK_W | Target bank |
| ap_i | input | 1 | Auto precharge on READ; all-banks on PRECHARGE |
| bl8_i | input | 1 | 1 = 8-beat burst, 0 = 4-beat burst |
| al_i | input | AL_W | Additive latency in clocks |
| cl_i | input | CL_W | CAS latency in clocks |
| err_bl4_cut_o | output | 1 | Sticky: 4-beat burst interrupted |
| err_bl8_cut_o | output | 1 | Sticky: 8-beat burst cut by a non-READ |
| err_bl8_align_o | output | 1 | Sticky: misaligned READ truncation |
| err_ap_cut_o | output | 1 | Sticky: auto-precharge burst truncated |
| err_rd2wr_o | output | 1 | Sticky: WRITE during read data |
| err_closed_o | output | 1 | Sticky: READ to a closed bank |
| viol_o | output | 1 | One-cycle pulse per violating command |
| row_open_o | output | NBANK | Per-bank open-row status |

## Verification
A wrong k counter or a wrongly latched burst length moves the edges of the legal windows. This shows as a pulse one clock after a command that sits exactly on a boundary (k = 2, k = H, k = RL + H), or as a missing pulse there, so the stimulus places commands on each boundary and on either side of it. A lost or late auto-precharge close shows up in `row_open_o` one clock after the expected closing edge, and again as a missing closed-bank error on the next READ to that bank. Sticky flags are compared as a set after a long mixed stream, so a flag that fires for the wrong rule also appears at the ports.

// File: rtl/ddr2_mon_pkg.sv
package ddr2_mon_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_READ  = 3'd1,
        CMD_WRITE = 3'd2,
        CMD_ACT   = 3'd3,
        CMD_PRE   = 3'd4
    } cmd_e;

    typedef struct packed {
        logic bl4_cut;
        logic bl8_cut;
        logic bl8_align;
        logic ap_cut;
        logic rd2wr;
        logic closed;
    } err_t;

    localparam int HALF_BL4  = 2;
    localparam int HALF_BL8  = 4;
    localparam int ALIGN_GAP = 2;

endpackage

// File: rtl/ddr2_burst_trk.sv
module ddr2_burst_trk
    import ddr2_mon_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int AL_W   = 3,
    parameter int CL_W   = 3,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic              ap_i,
    input  logic              bl8_i,
    input  logic [AL_W-1:0]   al_i,
    input  logic [CL_W-1:0]   cl_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  half_o,
    output logic [CNT_W-1:0]  dend_o,
    output logic              bl8_o,
    output logic              pend_o,
    output logic [BANK_W-1:0] pbank_o,
    output logic              close_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  half;
        logic [CNT_W-1:0]  dend;
        logic              bl8;
        logic              pend;
        logic [BANK_W-1:0] bank;
    } trk_t;

    trk_t trk_d, trk_q;
    logic close;

    always_comb begin
        trk_d = trk_q;
        close = trk_q.pend && (rd_i || (trk_q.cnt >= trk_q.half));
        if (close) begin
            trk_d.pend = 1'b0;
        end
        if (rd_i) begin
            trk_d.cnt  = CNT_W'(1);
            trk_d.half = bl8_i ? CNT_W'(HALF_BL8) : CNT_W'(HALF_BL4);
            trk_d.dend = CNT_W'(al_i) + CNT_W'(cl_i) + trk_d.half;
            trk_d.bl8  = bl8_i;
            trk_d.pend = ap_i;
            trk_d.bank = bank_i;
        end else if (trk_q.cnt != CNT_MAX) begin
            trk_d.cnt = trk_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q.cnt  <= CNT_MAX;
            trk_q.half <= CNT_W'(HALF_BL4);
            trk_q.dend <= '0;
            trk_q.bl8  <= 1'b0;
            trk_q.pend <= 1'b0;
            trk_q.bank <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign cnt_o   = trk_q.cnt;
    assign half_o  = trk_q.half;
    assign dend_o  = trk_q.dend;
    assign bl8_o   = trk_q.bl8;
    assign pend_o  = trk_q.pend;
    assign pbank_o = trk_q.bank;
    assign close_o = close;

endmodule

// File: rtl/ddr2_rule_chk.sv
module ddr2_rule_chk
    import ddr2_mon_pkg::*;
#(
    parameter int NBANK  = 8,
    parameter int BANK_W = 3,
    parameter int CNT_W  = 6
) (
    input  logic [2:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CNT_W-1:0]  half_i,
    input  logic [CNT_W-1:0]  dend_i,
    input  logic              bl8_i,
    input  logic              pend_i,
    input  logic [BANK_W-1:0] pbank_i,
    input  logic [NBANK-1:0]  row_open_i,
    output err_t              hit_o
);

    cmd_e cmd;
    logic in_burst, is_rd, busy_bank;

    always_comb begin
        cmd       = cmd_e'(cmd_i);
        is_rd     = (cmd == CMD_READ);
        in_burst  = (cnt_i < half_i);
        busy_bank = pend_i && (pbank_i == bank_i);

        hit_o           = '0;
        hit_o.bl4_cut   = in_burst && !bl8_i && (cmd != CMD_NOP);
        hit_o.bl8_cut   = in_burst && bl8_i && (cmd != CMD_NOP) && !is_rd;
        hit_o.bl8_align = in_burst && bl8_i && is_rd && (cnt_i != CNT_W'(ALIGN_GAP));
        hit_o.ap_cut    = in_burst && bl8_i && is_rd && pend_i;
        hit_o.rd2wr     = (cmd == CMD_WRITE) && (cnt_i < dend_i);
        hit_o.closed    = is_rd && (!row_open_i[bank_i] || busy_bank);
    end

endmodule

// File: rtl/ddr2_row_trk.sv
module ddr2_row_trk
    import ddr2_mon_pkg::*;
#(
    parameter int NBANK  = 8,
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic              ap_i,
    input  logic              close_i,
    input  logic [BANK_W-1:0] close_bank_i,
    output logic [NBANK-1:0]  row_open_o
);

    logic [NBANK-1:0] open_d, open_q;

    always_comb begin
        open_d = open_q;
        if (close_i) begin
            open_d[close_bank_i] = 1'b0;
        end
        case (cmd_e'(cmd_i))
            CMD_ACT: open_d[bank_i] = 1'b1;
            CMD_PRE: begin
                if (ap_i) open_d = '0;
                else      open_d[bank_i] = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) open_q <= '0;
        else        open_q <= open_d;
    end

    assign row_open_o = open_q;

endmodule

// File: rtl/ddr2_rd_mon.sv
module ddr2_rd_mon
    import ddr2_mon_pkg::*;
#(
    parameter int NBANK  = 8,
    parameter int BANK_W = $clog2(NBANK),
    parameter int AL_W   = 3,
    parameter int CL_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic              ap_i,
    input  logic              bl8_i,
    input  logic [AL_W-1:0]   al_i,
    input  logic [CL_W-1:0]   cl_i,
    output logic              err_bl4_cut_o,
    output logic              err_bl8_cut_o,
    output logic              err_bl8_align_o,
    output logic              err_ap_cut_o,
    output logic              err_rd2wr_o,
    output logic              err_closed_o,
    output logic              viol_o,
    output logic [NBANK-1:0]  row_open_o
);

    localparam int CNT_W = $clog2((1 << AL_W) + (1 << CL_W) + HALF_BL8) + 1;

    typedef struct packed {
        err_t err;
        logic viol;
    } mon_t;

    mon_t mon_d, mon_q;
    err_t hit;

    logic [CNT_W-1:0]  cnt, half, dend;
    logic              bl8, pend, close;
    logic [BANK_W-1:0] pbank;
    logic              rd;

    assign rd = (cmd_e'(cmd_i) == CMD_READ);

    ddr2_burst_trk #(
        .BANK_W(BANK_W), .AL_W(AL_W), .CL_W(CL_W), .CNT_W(CNT_W)
    ) u_trk (
        .clk(clk), .rst_n(rst_n), .rd_i(rd), .bank_i(bank_i), .ap_i(ap_i),
        .bl8_i(bl8_i), .al_i(al_i), .cl_i(cl_i),
        .cnt_o(cnt), .half_o(half), .dend_o(dend), .bl8_o(bl8),
        .pend_o(pend), .pbank_o(pbank), .close_o(close)
    );

    ddr2_rule_chk #(
        .NBANK(NBANK), .BANK_W(BANK_W), .CNT_W(CNT_W)
    ) u_rule (
        .cmd_i(cmd_i), .bank_i(bank_i), .cnt_i(cnt), .half_i(half),
        .dend_i(dend), .bl8_i(bl8), .pend_i(pend), .pbank_i(pbank),
        .row_open_i(row_open_o), .hit_o(hit)
    );

    ddr2_row_trk #(
        .NBANK(NBANK), .BANK_W(BANK_W)
    ) u_row (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i), .ap_i(ap_i),
        .close_i(close), .close_bank_i(pbank), .row_open_o(row_open_o)
    );

    always_comb begin
        mon_d      = mon_q;
        mon_d.err  = mon_q.err | hit;
        mon_d.viol = |hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mon_q <= '0;
        else        mon_q <= mon_d;
    end

    assign err_bl4_cut_o   = mon_q.err.bl4_cut;
    assign err_bl8_cut_o   = mon_q.err.bl8_cut;
    assign err_bl8_align_o = mon_q.err.bl8_align;
    assign err_ap_cut_o    = mon_q.err.ap_cut;
    assign err_rd2wr_o     = mon_q.err.rd2wr;
    assign err_closed_o    = mon_q.err.closed;
    assign viol_o          = mon_q.viol;

endmodule

// File: rtl/ddr2_rd_mon_chk.sv
module ddr2_rd_mon_chk #(
    parameter int NBANK = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cmd_i,
    input logic             ap_i,
    input logic             viol_o,
    input logic [5:0]       flags,
    input logic [NBANK-1:0] row_open_o
);

    assert_pulse_has_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> (flags != 6'd0));

    assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((flags & $past(flags)) == $past(flags)));

    assert_nop_no_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd0) |=> !viol_o);

    assert_row_rise_on_act_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ((row_open_o & ~$past(row_open_o)) != '0))
            |-> ($past(cmd_i) == 3'd3));

    assert_row_rise_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(row_open_o & ~$past(row_open_o)) <= 1));

    assert_pre_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd4 && ap_i) |=> (row_open_o == '0));

    assert_write_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cmd_i == 3'd2 && $past(cmd_i) == 3'd1) |=> viol_o);

endmodule

bind ddr2_rd_mon ddr2_rd_mon_chk #(.NBANK(NBANK)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .ap_i(ap_i), .viol_o(viol_o),
    .flags({err_bl4_cut_o, err_bl8_cut_o, err_bl8_align_o,
            err_ap_cut_o, err_rd2wr_o, err_closed_o}),
    .row_open_o(row_open_o)
);

// File: tb/test_ddr2_rd_mon.sv
module test_ddr2_rd_mon;

    localparam int PERIOD = 10;
    localparam int NB = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic [2:0] bank = 3'd0;
    logic       ap = 1'b0;
    logic       bl8 = 1'b0;
    logic [2:0] al = 3'd1;
    logic [2:0] cl = 3'd3;
    logic       e_b4, e_b8, e_al, e_ap, e_wr, e_cl, viol;
    logic [NB-1:0] rows;
    logic [5:0] flags;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    ddr2_rd_mon #(.NBANK(NB)) i_ddr2_rd_mon (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bank_i(bank), .ap_i(ap),
        .bl8_i(bl8), .al_i(al), .cl_i(cl),
        .err_bl4_cut_o(e_b4), .err_bl8_cut_o(e_b8), .err_bl8_align_o(e_al),
        .err_ap_cut_o(e_ap), .err_rd2wr_o(e_wr), .err_closed_o(e_cl),
        .viol_o(viol), .row_open_o(rows)
    );

    assign flags = {e_b4, e_b8, e_al, e_ap, e_wr, e_cl};

    typedef struct packed {
        logic [2:0] c;
        logic [2:0] b;
        logic       a;
        logic       l8;
        logic       v;
        logic [7:0] r;
    } vec_t;

    // al=1, cl=3 -> RL=4
    localparam vec_t VEC [38] = '{
        '{3'd3,3'd0,1'b0,1'b0,1'b0,8'h01}, // 0  ACT b0            R8
        '{3'd3,3'd1,1'b0,1'b0,1'b0,8'h03}, // 1  ACT b1
        '{3'd1,3'd0,1'b0,1'b0,1'b0,8'h03}, // 2  READ b0 BL4
        '{3'd0,3'd0,1'b0,1'b0,1'b0,8'h03}, // 3
        '{3'd1,3'd1,1'b0,1'b0,1'b0,8'h03}, // 4  seamless READ k=2  R7
        '{3'd0,3'd0,1'b0,1'b0,1'b0,8'h03},
        '{3'd0,3'd0,1'b0,1'b0,1'b0,8'h03},
        '{3'd0,3'd0,1'b0,1'b0,1'b0,8'h03},
        '{3'd0,3'd0,1'b0,1'b0,1'b0,8'h03},
        '{3'd2,3'd1,1'b0,1'b0,1'b1,8'h03}, // 9  WRITE k=5 < 6     R6
        '{3'd2,3'd1,1'b0,1'b0,1'b0,8'h03}, // 10 WRITE k=6         R6
        '{3'd1,3'd0,1'b0,1'b1,1'b0,8'h03}, // 11 READ b0 BL8
        '{3'd0,3'd0,1'b0,1'b0,1'b0,8'h03},
        '{3'd1,3'd0,1'b0,1'b1,1'b0,8'h03}, // 13 READ k=2 legal    R4
        '{3'd1,3'd0,1'b0,1'b1,1'b1,8'h03}, // 14 READ k=1          R4
        '{3'd0,3'd0,1'b0,1'b0,1'b0,8'h03},
        '{3'd4,3'd0,1'b0,1'b0,1'b1,8'h02}, // 16 PRE b0 k=2 BL8    R3 R8
        '{3'd0,3'd0,1'b0,1'b0,1'b0,8'h02},
        '{3'd0,3'd0,1'b0,1'b0,1'b0,8'h02},
        '{3'd1,3'd0,1'b0,1'b0,1'b1,8'h02}, // 19 READ closed b0    R9
        '{3'd0,3'd0,1'b0,1'b0,1'b0,8'h02},
        '{3'd0,3'd0,1'b0,1'b0,1'b0,8'h02},
        '{3'd3,3'd2,1'b0,1'b0,1'b0,8'h06}, // 22 ACT b2
        '{3'd1,3'd2,1'b1,1'b1,1'b0,8'h06}, // 23 READ b2 AP BL8
        '{3'd0,3'd0,1'b0,1'b0,1'b0,8'h06},
        '{3'd1,3'd1,1'b0,1'b1,1'b1,8'h02}, // 25 READ k=2 on AP    R5 R9
        '{3'd0,3'd0,1'b0,1'b0,1'b0,8'h02},
        '{3'd0,3'd0,1'b0,1'b0,1'b0,8'h02},
        '{3'd0,3'd0,1'b0,1'b0,1'b0,8'h02},
        '{3'd1,3'd1,1'b1,1'b0,1'b0,8'h02}, // 29 READ b1 AP BL4
        '{3'd0,3'd0,1'b0,1'b0,1'b0,8'h02}, // 30 k=1 still open    R9
        '{3'd0,3'd0,1'b0,1'b0,1'b0,8'h00}, // 31 k=2 closed        R9
        '{3'd3,3'd1,1'b0,1'b0,1'b0,8'h02},
        '{3'd1,3'd1,1'b0,1'b0,1'b0,8'h02}, // 33 READ BL4
        '{3'd3,3'd3,1'b0,1'b0,1'b1,8'h0A}, // 34 ACT k=1           R2
        '{3'd0,3'd0,1'b0,1'b0,1'b0,8'h0A},
        '{3'd4,3'd0,1'b1,1'b0,1'b0,8'h00}, // 36 PRE all           R8
        '{3'd5,3'd0,1'b0,1'b0,1'b0,8'h00}  // 37 other
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] c, input logic [2:0] b, input logic a, input logic l8);
        @(negedge clk);
        cmd = c; bank = b; ap = a; bl8 = l8;
        @(posedge clk);
        #1;
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) step(3'd0, 3'd0, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd = 3'd0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        #1;
        chk("R1 flags", 32'(flags), 32'h0);
        chk("R1 viol", 32'(viol), 32'h0);
        chk("R1 rows", 32'(rows), 32'h0);

        for (int i = 0; i < 38; i++) begin
            step(VEC[i].c, VEC[i].b, VEC[i].a, VEC[i].l8);
            chk($sformatf("R10 pulse vec%0d", i), 32'(viol), 32'(VEC[i].v));
            chk($sformatf("R8 rows vec%0d", i), 32'(rows), 32'(VEC[i].r));
        end
        chk("R10 all flags sticky", 32'(flags), 32'h3F);

        do_reset();
        #1;
        chk("R1 flags after reset", 32'(flags), 32'h0);
        chk("R1 rows after reset", 32'(rows), 32'h0);

        // R6 boundary with RL=5, BL8: WRITE at k=8 illegal
        al = 3'd0; cl = 3'd5;
        step(3'd3, 3'd3, 1'b0, 1'b0);
        step(3'd1, 3'd3, 1'b0, 1'b1);
        nops(7);
        step(3'd2, 3'd3, 1'b0, 1'b0);
        chk("R6 write k=8 flag", 32'(flags), 32'h02);
        chk("R6 write k=8 pulse", 32'(viol), 32'h1);
        step(3'd0, 3'd0, 1'b0, 1'b0);
        chk("R10 pulse one cycle", 32'(viol), 32'h0);
        chk("R10 flag held", 32'(flags), 32'h02);

        // R6 WRITE at k=9 legal
        do_reset();
        step(3'd3, 3'd3, 1'b0, 1'b0);
        step(3'd1, 3'd3, 1'b0, 1'b1);
        nops(8);
        step(3'd2, 3'd3, 1'b0, 1'b0);
        chk("R6 write k=9 legal", 32'(flags), 32'h0);

        // R4 READ at k=3 on BL8
        do_reset();
        al = 3'd1; cl = 3'd3;
        step(3'd3, 3'd0, 1'b0, 1'b0);
        step(3'd1, 3'd0, 1'b0, 1'b1);
        nops(2);
        step(3'd1, 3'd0, 1'b0, 1'b1);
        chk("R4 read k=3 only align", 32'(flags), 32'h08);

        // R7 seamless after AP BL8 to other bank, R9 close at k=4
        do_reset();
        step(3'd3, 3'd4, 1'b0, 1'b0);
        step(3'd3, 3'd5, 1'b0, 1'b0);
        step(3'd1, 3'd4, 1'b1, 1'b1);
        nops(3);
        chk("R9 AP row still open", 32'(rows), 32'h30);
        step(3'd1, 3'd5, 1'b0, 1'b1);
        chk("R7 seamless no flag", 32'(flags), 32'h0);
        chk("R7 seamless no pulse", 32'(viol), 32'h0);
        chk("R9 AP row closed", 32'(rows), 32'h20);
        nops(3);
        step(3'd1, 3'd4, 1'b0, 1'b1);
        chk("R9 read closed bank", 32'(flags), 32'h01);

        // R9 READ to bank with pending AP close at k=H
        do_reset();
        step(3'd3, 3'd6, 1'b0, 1'b0);
        step(3'd1, 3'd6, 1'b1, 1'b0);
        step(3'd0, 3'd0, 1'b0, 1'b0);
        step(3'd1, 3'd6, 1'b0, 1'b0);
        chk("R9 pending close read", 32'(flags), 32'h01);
        chk("R9 pending bank closed", 32'(rows), 32'h0);

        // R2 BL4 cut by a WRITE also breaks R6
        do_reset();
        step(3'd3, 3'd7, 1'b0, 1'b0);
        step(3'd1, 3'd7, 1'b0, 1'b0);
        step(3'd2, 3'd7, 1'b0, 1'b0);
        chk("R2 write k=1 flags", 32'(flags), 32'h22);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule